// File: doc/BRIEF.md
# Wishbone to Asynchronous Strobed 16-bit Bus Bridge

This block is a Wishbone slave with a 32-bit data path and byte selects. It turns each Wishbone access into one or two handshaked cycles on an asynchronous, big-endian 16-bit bus. That bus has an address strobe, an upper and a lower data strobe, a read/write line and a 3-bit function code. Each cycle completes only when the target pulls its acknowledge low. The acknowledge is brought into the clock domain through a synchronizer before the state machine acts on it.

The byte selects decide which half-words are touched. If both halves hold selected lanes, the bridge runs two cycles, even half first, and returns the Wishbone acknowledge only after the second. A function code of 7 marks an interrupt-acknowledge access. That access is always a single read of the odd half-word. The strobes stay low until the master removes its request, and then they are released.

Top module: `wb_strobe_bridge`

## Requirements
- R1: While reset is high, and after it, the bus sits idle. `bus_astb_n`, `bus_hi_n` and `bus_lo_n` are high, `bus_rd` is high and `wb_ack` is low.
- R2: The strobes fall only in response to a request with both `wb_cyc` and `wb_stb` high, and only after the synchronized acknowledge has been seen released. With the acknowledge already released, they fall in the first clock after the request.
- R3: `bus_astb_n` is low exactly when at least one of `bus_hi_n` and `bus_lo_n` is low.
- R4: `wb_ack` is a one-clock pulse. It appears 3 clocks after `bus_ack_n` goes low on the final cycle, and the strobes are still low when it does. The strobes stay low until the master drops `wb_cyc`/`wb_stb`, and go high one clock after the bridge observes the drop.
- R5: `bus_addr` is the low 23 bits of `{wb_adr, h}`. Here h=0 for the even half-word (select bits 3 and 2) and h=1 for the odd half-word (select bits 1 and 0). The address is stable while `bus_astb_n` is low.
- R6: On the even half, `bus_hi_n` is low when select bit 3 is set and `bus_lo_n` when bit 2 is set. On the odd half, bit 1 drives `bus_hi_n` and bit 0 drives `bus_lo_n`.
- R7: A select pattern with lanes in both halves runs two cycles, even half first. An all-zero select counts as all four lanes. Between the two cycles all strobes are high for at least one clock. The second cycle starts 3 clocks after the strobes rise when the target releases its acknowledge immediately.
- R8: On a read, the even half-word is returned in `wb_dat_r[31:16]` and the odd half-word in `wb_dat_r[15:0]`. A half that was not accessed reads zero. The data is valid while `wb_ack` is high.
- R9: On a write, `bus_rd` is low for the whole cycle. `bus_dout` carries `wb_dat_w[31:16]` on the even half and `wb_dat_w[15:0]` on the odd half.
- R10: With `wb_fc` = 7, the access is one read cycle at the odd half-word address with both data strobes low, whatever `wb_sel` and `wb_we` hold. In every cycle, `bus_fc` equals the `wb_fc` of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | WB_AW (30) | Wishbone word address |
| wb_sel | input | 4 | Byte lane selects |
| wb_dat_w | input | 32 | Write data |
| wb_fc | input | FC_W (3) | Function code for the access |
| wb_ack | output | 1 | Access complete pulse |
| wb_dat_r | output | 32 | Read data |
| bus_addr | output | BUS_AW (23) | Half-word address |
| bus_astb_n | output | 1 | Address strobe, active low |
| bus_hi_n | output | 1 | Even-byte data strobe, active low |
| bus_lo_n | output | 1 | Odd-byte data strobe, active low |
| bus_rd | output | 1 | High for read, low for write |
| bus_fc | output | FC_W (3) | Function code on the bus |
| bus_dout | output | 16 | Write data to the target |
| bus_din | input | 16 | Read data from the target |
| bus_ack_n | input | 1 | Target acknowledge, active low, asynchronous |

## Verification
A wrong state or half index shows up at the bus pins within one clock of the strobes falling: a wrong address low bit, the wrong strobe pair, or the wrong data half. A broken split shows as a missing or misordered second fall, or as a Wishbone acknowledge after only one cycle. A fault in the synchronizer or the completion path moves `wb_ack` off its fixed three-clock distance from the target acknowledge, so it is caught in that same access. A fault in the release path leaves the strobes low two clocks after the request drops.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int BUS_DW = 16;
  localparam int WB_DW  = 2 * BUS_DW;
  localparam int SEL_W  = WB_DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_GAP,
    ST_ACK,
    ST_HOLD
  } bstate_e;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_lane.sv
module bridge_lane
  import bridge_pkg::*;
#(
  parameter int WB_AW   = 30,
  parameter int BUS_AW  = 23,
  parameter int FC_W    = 3,
  parameter int FC_IACK = 7
) (
  input  logic [WB_AW-1:0]  adr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WB_DW-1:0]  dat_w,
  input  logic              we,
  input  logic [FC_W-1:0]   fc,
  input  logic              half,
  output logic              two_o,
  output logic              first_o,
  output logic [BUS_AW-1:0] addr_o,
  output logic              hi_n_o,
  output logic              lo_n_o,
  output logic [BUS_DW-1:0] dout_o,
  output logic              rd_o
);
  logic [SEL_W-1:0] sel_eff;
  logic has_even, has_odd, iack;

  // An empty select is taken as the whole word
  assign sel_eff  = (sel == '0) ? '1 : sel;
  assign has_even = |sel_eff[3:2];
  assign has_odd  = |sel_eff[1:0];
  assign iack     = (fc == FC_W'(FC_IACK));

  assign two_o   = !iack && has_even && has_odd;
  assign first_o = iack || !has_even;

  // Word address shifted up one, half index in the low bit
  assign addr_o = BUS_AW'({adr, half});

  always_comb begin
    if (iack) begin
      hi_n_o = 1'b0;
      lo_n_o = 1'b0;
    end else if (half) begin
      hi_n_o = !sel_eff[1];
      lo_n_o = !sel_eff[0];
    end else begin
      hi_n_o = !sel_eff[3];
      lo_n_o = !sel_eff[2];
    end
  end

  assign dout_o = (we && !iack) ? (half ? dat_w[BUS_DW-1:0] : dat_w[WB_DW-1:BUS_DW])
                                : '0;
  assign rd_o   = iack || !we;
endmodule

// File: rtl/wb_strobe_bridge.sv
module wb_strobe_bridge
  import bridge_pkg::*;
#(
  parameter int WB_AW       = 30,
  parameter int BUS_AW      = 23,
  parameter int FC_W        = 3,
  parameter int FC_IACK     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [WB_AW-1:0]  wb_adr,
  input  logic [3:0]        wb_sel,
  input  logic [31:0]       wb_dat_w,
  input  logic [FC_W-1:0]   wb_fc,
  output logic              wb_ack,
  output logic [31:0]       wb_dat_r,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_astb_n,
  output logic              bus_hi_n,
  output logic              bus_lo_n,
  output logic              bus_rd,
  output logic [FC_W-1:0]   bus_fc,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din,
  input  logic              bus_ack_n
);
  bstate_e state;
  logic ack_s_n;
  logic two_q, half_q;
  logic req;

  logic              ln_two, ln_first, ln_half;
  logic [BUS_AW-1:0] ln_addr;
  logic              ln_hi_n, ln_lo_n, ln_rd;
  logic [BUS_DW-1:0] ln_dout;

  assign req = wb_cyc && wb_stb;

  bridge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_ack_n),
    .q   (ack_s_n)
  );

  // Idle plans the first half; the gap always leads to the odd half
  assign ln_half = (state == ST_IDLE) ? ln_first : 1'b1;

  bridge_lane #(
    .WB_AW(WB_AW), .BUS_AW(BUS_AW), .FC_W(FC_W), .FC_IACK(FC_IACK)
  ) u_lane (
    .adr     (wb_adr),
    .sel     (wb_sel),
    .dat_w   (wb_dat_w),
    .we      (wb_we),
    .fc      (wb_fc),
    .half    (ln_half),
    .two_o   (ln_two),
    .first_o (ln_first),
    .addr_o  (ln_addr),
    .hi_n_o  (ln_hi_n),
    .lo_n_o  (ln_lo_n),
    .dout_o  (ln_dout),
    .rd_o    (ln_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wb_ack     <= 1'b0;
      wb_dat_r   <= '0;
      bus_addr   <= '0;
      bus_astb_n <= 1'b1;
      bus_hi_n   <= 1'b1;
      bus_lo_n   <= 1'b1;
      bus_rd     <= 1'b1;
      bus_fc     <= '0;
      bus_dout   <= '0;
      two_q      <= 1'b0;
      half_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req && ack_s_n) begin
            bus_addr   <= ln_addr;
            bus_hi_n   <= ln_hi_n;
            bus_lo_n   <= ln_lo_n;
            bus_rd     <= ln_rd;
            bus_dout   <= ln_dout;
            bus_fc     <= wb_fc;
            bus_astb_n <= 1'b0;
            two_q      <= ln_two;
            half_q     <= ln_first;
            wb_dat_r   <= '0;
            state      <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (!ack_s_n) begin
            if (half_q) wb_dat_r[15:0]  <= bus_din;
            else        wb_dat_r[31:16] <= bus_din;
            if (two_q && !half_q) begin
              bus_astb_n <= 1'b1;
              bus_hi_n   <= 1'b1;
              bus_lo_n   <= 1'b1;
              state      <= ST_GAP;
            end else begin
              wb_ack <= 1'b1;
              state  <= ST_ACK;
            end
          end
        end
        ST_GAP: begin
          if (ack_s_n) begin
            bus_addr   <= ln_addr;
            bus_hi_n   <= ln_hi_n;
            bus_lo_n   <= ln_lo_n;
            bus_dout   <= ln_dout;
            bus_astb_n <= 1'b0;
            half_q     <= 1'b1;
            state      <= ST_DRIVE;
          end
        end
        ST_ACK: begin
          wb_ack <= 1'b0;
          state  <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!req) begin
            bus_astb_n <= 1'b1;
            bus_hi_n   <= 1'b1;
            bus_lo_n   <= 1'b1;
            bus_rd     <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int BUS_AW  = 23,
  parameter int FC_W    = 3,
  parameter int FC_IACK = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_ack,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_astb_n,
  input logic              bus_hi_n,
  input logic              bus_lo_n,
  input logic              bus_rd,
  input logic [FC_W-1:0]   bus_fc
);
  a_r3_strobe_pair: assert property (@(posedge clk) disable iff (rst)
    bus_astb_n == (bus_hi_n && bus_lo_n));

  a_r2_fall_on_request: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_astb_n) |-> $past(wb_cyc && wb_stb));

  a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  a_r4_ack_with_strobe: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> !bus_astb_n);

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!bus_astb_n && $past(!bus_astb_n)) |-> ($stable(bus_addr) && $stable(bus_rd)));

  a_r7_gap_high: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_astb_n) |=> bus_astb_n);

  a_r10_iack_odd_read: assert property (@(posedge clk) disable iff (rst)
    (!bus_astb_n && bus_fc == FC_W'(FC_IACK)) |-> (bus_addr[0] && bus_rd && !bus_hi_n && !bus_lo_n));
endmodule

bind wb_strobe_bridge bridge_checker #(
  .BUS_AW(BUS_AW), .FC_W(FC_W), .FC_IACK(FC_IACK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wb_cyc     (wb_cyc),
  .wb_stb     (wb_stb),
  .wb_ack     (wb_ack),
  .bus_addr   (bus_addr),
  .bus_astb_n (bus_astb_n),
  .bus_hi_n   (bus_hi_n),
  .bus_lo_n   (bus_lo_n),
  .bus_rd     (bus_rd),
  .bus_fc     (bus_fc)
);

// File: tb/wb_strobe_bridge_test.sv
module wb_strobe_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [29:0] wb_adr = '0;
  logic [3:0]  wb_sel = '0;
  logic [31:0] wb_dat_w = '0;
  logic [2:0]  wb_fc = '0;
  logic        wb_ack;
  logic [31:0] wb_dat_r;
  logic [22:0] bus_addr;
  logic        bus_astb_n, bus_hi_n, bus_lo_n, bus_rd;
  logic [2:0]  bus_fc;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        bus_ack_n = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wb_strobe_bridge uut (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_fc(wb_fc),
    .wb_ack(wb_ack), .wb_dat_r(wb_dat_r), .bus_addr(bus_addr),
    .bus_astb_n(bus_astb_n), .bus_hi_n(bus_hi_n), .bus_lo_n(bus_lo_n),
    .bus_rd(bus_rd), .bus_fc(bus_fc), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One Wishbone access, with the target modelled behaviourally
  task automatic access(input logic [29:0] a, input logic [3:0] s, input bit w,
                        input logic [31:0] d, input logic [2:0] f, input int lat);
    logic [3:0]  se;
    int          nh;
    logic [22:0] ea [2];
    logic        eh [2];
    logic        el [2];
    logic        ev [2];
    logic [15:0] ed [2];
    logic [31:0] er;
    logic        erd;
    logic [15:0] resp;
    int          n;
    se  = (s == 4'h0) ? 4'hF : s;
    erd = (f == 3'd7) || !w;
    nh  = 0;
    if (f == 3'd7) begin
      ea[0] = 23'({a, 1'b1}); eh[0] = 0; el[0] = 0; ev[0] = 0; ed[0] = 16'h0; nh = 1;
    end else begin
      if (se[3] || se[2]) begin
        ea[nh] = 23'({a, 1'b0}); eh[nh] = !se[3]; el[nh] = !se[2]; ev[nh] = 1;
        ed[nh] = d[31:16]; nh++;
      end
      if (se[1] || se[0]) begin
        ea[nh] = 23'({a, 1'b1}); eh[nh] = !se[1]; el[nh] = !se[0]; ev[nh] = 0;
        ed[nh] = d[15:0]; nh++;
      end
    end
    er = '0;
    repeat (4) @(negedge clk);
    wb_adr = a; wb_sel = s; wb_we = w; wb_dat_w = d; wb_fc = f;
    wb_cyc = 1; wb_stb = 1;
    for (int h = 0; h < nh; h++) begin
      n = 0;
      while (bus_astb_n && n < 20) begin @(negedge clk); n++; end
      if (h == 0) chk("R2", "clocks to first strobe fall", n, 1);
      else        chk("R7", "clocks to second strobe fall", n, 3);
      for (int c = 0; c <= lat; c++) begin
        if (c > 0) @(negedge clk);
        chk("R5", "address", bus_addr, ea[h]);
        chk("R6", "upper strobe", bus_hi_n, eh[h]);
        chk("R6", "lower strobe", bus_lo_n, el[h]);
        chk("R3", "address strobe", bus_astb_n, 0);
        if (f == 3'd7) chk("R10", "iack read line", bus_rd, 1);
        else           chk("R9", "read/write line", bus_rd, erd);
        chk("R10", "function code", bus_fc, f);
        if (!erd) chk("R9", "write data", bus_dout, ed[h]);
        chk("R4", "no early ack", wb_ack, 0);
      end
      resp = ea[h][15:0] ^ 16'hC3A5;
      bus_din = resp; bus_ack_n = 0;
      if (ev[h]) er[31:16] = resp; else er[15:0] = resp;
      repeat (2) begin
        @(negedge clk);
        chk("R4", "strobe held during sync", bus_astb_n, 0);
        chk("R4", "ack waits for sync", wb_ack, 0);
      end
      @(negedge clk);
      if (h == nh - 1) begin
        chk("R4", "ack after final half", wb_ack, 1);
        chk("R4", "strobe low at ack", bus_astb_n, 0);
        if (erd) chk("R8", "read data", wb_dat_r, er);
      end else begin
        chk("R7", "strobes high in gap", {bus_astb_n, bus_hi_n, bus_lo_n}, 3'b111);
        bus_ack_n = 1;
      end
    end
    wb_cyc = 0; wb_stb = 0;
    @(negedge clk);
    chk("R4", "ack single pulse", wb_ack, 0);
    chk("R4", "strobe held until drop seen", bus_astb_n, 0);
    @(negedge clk);
    chk("R4", "strobes released", {bus_astb_n, bus_hi_n, bus_lo_n}, 3'b111);
    bus_ack_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", {bus_astb_n, bus_hi_n, bus_lo_n}, 3'b111);
    chk("R1", "ack in reset", wb_ack, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "read line idle", bus_rd, 1);
    chk("R1", "strobes idle", {bus_astb_n, bus_hi_n, bus_lo_n}, 3'b111);
    // R6 R8: single byte reads in each lane
    access(30'h0, 4'b0001, 0, 32'h0, 3'd1, 0);
    access(30'h0, 4'b0010, 0, 32'h0, 3'd1, 1);
    access(30'h0, 4'b0100, 0, 32'h0, 3'd1, 2);
    access(30'h0, 4'b1000, 0, 32'h0, 3'd1, 3);
    // R7: full word split
    access(30'h0AAA, 4'hF, 0, 32'h0, 3'd2, 1);
    // half-word reads
    access(30'h1234, 4'b0011, 0, 32'h0, 3'd5, 0);
    access(30'h1234, 4'b1100, 0, 32'h0, 3'd5, 0);
    // R9: writes
    access(30'h0155, 4'hF, 1, 32'hDEAD_BEEF, 3'd1, 2);
    access(30'h0042, 4'b0010, 1, 32'h1122_3344, 3'd1, 0);
    // R7: scattered lanes and empty select
    access(30'h0777, 4'b1001, 0, 32'h0, 3'd6, 1);
    access(30'h0321, 4'b0000, 1, 32'hCAFE_F00D, 3'd1, 0);
    // R10: interrupt acknowledge with write and partial select requested
    access(30'h3FFF_FFF9, 4'b0100, 1, 32'h0, 3'd7, 1);
    // R5: high address bits fall off
    access(30'h3FFF_FFFF, 4'b0001, 0, 32'h0, 3'd0, 0);
    repeat (4) @(negedge clk);
    chk("R2", "no strobe without request", bus_astb_n, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule